// File: doc/BRIEF.md
# Channel Zero-Suppression Packer

The packer sits behind a bank of sixteen ADC channels that each present one sample on every event clock. On each clock where the input is marked valid, it tests every sample against a shared threshold that can change from event to event. It then produces three results together: a bitmap of the channels that passed, the sum of their full-width samples, and a compact list of short amplitude codes for those channels only. The list goes into a fixed 64-bit word so that a downstream serial link can send one event in a constant-size frame.

Each amplitude code is the sample shifted right by a programmable amount and then clamped to four bits. The codes are placed one after another in channel order, and the nibbles left over are filled with zero. A count of the passing channels is given with the frame, so the receiver knows how many nibbles are meaningful. All results are registered and appear one clock after the sample. When no sample is presented, the result registers keep their last values.

Top module: `zsp_packer`

## Requirements
- R1: Bit i of `out_mask` is 1 exactly when channel i's sample (bits [14*i+13:14*i] of `in_samples`) is strictly greater than `in_thresh`. A sample equal to the threshold is not a hit.
- R2: The code of a passing channel is its sample shifted right by `in_shift` bits. If the shifted value is above 15, the code is 15.
- R3: The codes of passing channels are placed in ascending channel order. The lowest passing channel goes in nibble 0 (`out_list[3:0]`), the next one in nibble 1 (`out_list[7:4]`), and so on.
- R4: Every nibble of `out_list` at position `out_count` or above is zero.
- R5: `out_count` equals the number of passing channels, from 0 up to 16.
- R6: `out_sum` is the sum of the full 14-bit samples of the passing channels only. It is zero when no channel passes.
- R7: When the true sum is above 65535, `out_sum` is 16'hFFFF.
- R8: A sample set taken with `in_valid` high shows up on the outputs one clock later, with `out_valid` high for exactly that clock.
- R9: A clock with `in_valid` low gives `out_valid` low on the next clock. On that clock, `out_mask`, `out_count`, `out_sum` and `out_list` keep their previous values.
- R10: While `rst_n` is low, all outputs are zero. Reset takes effect at once, without waiting for a clock. Its release takes effect two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low reset; asserts at once, releases after two clock edges |
| in_valid | input | 1 | Sample set on this clock is to be processed |
| in_samples | input | 224 | Sixteen 14-bit samples; channel i in bits [14*i+13:14*i] |
| in_thresh | input | 14 | Hit threshold; a hit needs a sample strictly above it |
| in_shift | input | 4 | Right-shift applied before the code is clamped to 15 |
| out_valid | output | 1 | Frame outputs hold a new event |
| out_mask | output | 16 | Hit bitmap, bit i for channel i |
| out_count | output | 5 | Number of hits, 0 to 16 |
| out_sum | output | 16 | Saturating sum of the hit samples |
| out_list | output | 64 | Packed 4-bit codes in channel order, unused nibbles zero |

## Verification
The assertions assume that `in_valid`, `in_samples`, `in_thresh` and `in_shift` have known values at every clock edge once the internal reset has been released. They also assume that nothing is offered during the two-edge release window. The stimulus drives every input on the falling edge and leaves `in_valid` low until the release has taken effect. Random frames pick a threshold and a shift for each event, and about a quarter of the clocks carry no valid data. This keeps the hold behaviour exercised without ever leaving an input unknown.

// File: rtl/zsp_pkg.sv
package zsp_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;
endpackage

// File: rtl/zsp_rst_sync.sv
module zsp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/zsp_chan_cond.sv
module zsp_chan_cond
  import zsp_pkg::*;
#(
  parameter int unsigned ADC_W   = 14,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic [ADC_W-1:0]   sample,
  input  logic [ADC_W-1:0]   thresh,
  input  logic [SHIFT_W-1:0] shift,
  output logic               hit,
  output logic [CODE_W-1:0]  code
);
  logic [ADC_W-1:0] scaled;

  always_comb begin
    hit    = (sample > thresh);
    scaled = sample >> shift;
    if (|scaled[ADC_W-1:CODE_W]) code = CODE_W'(CODE_MAX);
    else                         code = scaled[CODE_W-1:0];
  end
endmodule

// File: rtl/zsp_compactor.sv
module zsp_compactor
  import zsp_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CNT_W  = $clog2(NUM_CH + 1)
) (
  input  logic [NUM_CH-1:0]        hit,
  input  logic [NUM_CH*CODE_W-1:0] codes,
  output logic [NUM_CH*CODE_W-1:0] list,
  output logic [CNT_W-1:0]         count
);
  logic [CNT_W-1:0] slot_of [NUM_CH];

  // running prefix count: channel i lands in the slot equal to hits below it
  always_comb begin
    logic [CNT_W-1:0] run;
    run = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      slot_of[i] = run;
      run        = run + CNT_W'(hit[i]);
    end
    count = run;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_slot
    always_comb begin
      logic [CODE_W-1:0] pick;
      pick = '0;
      for (int i = k; i < NUM_CH; i++) begin
        if (hit[i] && (slot_of[i] == CNT_W'(k)))
          pick = pick | codes[i*CODE_W +: CODE_W];
      end
      list[k*CODE_W +: CODE_W] = pick;
    end
  end
endmodule

// File: rtl/zsp_sum.sv
module zsp_sum #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADC_W  = 14,
  parameter int unsigned SUM_W  = 16
) (
  input  logic [NUM_CH-1:0]       hit,
  input  logic [NUM_CH*ADC_W-1:0] samples,
  output logic [SUM_W-1:0]        sum
);
  localparam int unsigned ACC_W = ADC_W + $clog2(NUM_CH + 1);

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit[i]) acc = acc + ACC_W'(samples[i*ADC_W +: ADC_W]);
    end
  end

  if (ACC_W > SUM_W) begin : g_sat
    always_comb begin
      if (|acc[ACC_W-1:SUM_W]) sum = '1;
      else                     sum = acc[SUM_W-1:0];
    end
  end else begin : g_wide
    assign sum = SUM_W'(acc);
  end
endmodule

// File: rtl/zsp_packer.sv
module zsp_packer
  import zsp_pkg::*;
#(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned ADC_W   = 14,
  parameter int unsigned SHIFT_W = 4,
  parameter int unsigned SUM_W   = 16,
  localparam int unsigned CNT_W  = $clog2(NUM_CH + 1),
  localparam int unsigned LIST_W = NUM_CH * CODE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [NUM_CH*ADC_W-1:0] in_samples,
  input  logic [ADC_W-1:0]        in_thresh,
  input  logic [SHIFT_W-1:0]      in_shift,
  output logic                    out_valid,
  output logic [NUM_CH-1:0]       out_mask,
  output logic [CNT_W-1:0]        out_count,
  output logic [SUM_W-1:0]        out_sum,
  output logic [LIST_W-1:0]       out_list
);
  logic rst_sync_n;

  zsp_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [NUM_CH-1:0]        hit_c;
  logic [NUM_CH*CODE_W-1:0] code_c;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    zsp_chan_cond #(.ADC_W(ADC_W), .SHIFT_W(SHIFT_W)) i_cond (
      .sample (in_samples[c*ADC_W +: ADC_W]),
      .thresh (in_thresh),
      .shift  (in_shift),
      .hit    (hit_c[c]),
      .code   (code_c[c*CODE_W +: CODE_W])
    );
  end

  logic [LIST_W-1:0] list_c;
  logic [CNT_W-1:0]  count_c;
  logic [SUM_W-1:0]  sum_c;

  zsp_compactor #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_compact (
    .hit   (hit_c),
    .codes (code_c),
    .list  (list_c),
    .count (count_c)
  );

  zsp_sum #(.NUM_CH(NUM_CH), .ADC_W(ADC_W), .SUM_W(SUM_W)) i_sum (
    .hit     (hit_c),
    .samples (in_samples),
    .sum     (sum_c)
  );

  // next-state
  logic                    frame_en;
  logic                    valid_d;
  logic [NUM_CH-1:0]       mask_d;
  logic [CNT_W-1:0]        count_d;
  logic [SUM_W-1:0]        sum_d;
  logic [LIST_W-1:0]       list_d;

  always_comb begin
    frame_en = in_valid;
    valid_d  = in_valid;
    mask_d   = out_mask;
    count_d  = out_count;
    sum_d    = out_sum;
    list_d   = out_list;
    if (frame_en) begin
      mask_d  = hit_c;
      count_d = count_c;
      sum_d   = sum_c;
      list_d  = list_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_count <= '0;
      out_sum   <= '0;
      out_list  <= '0;
    end else begin
      out_valid <= valid_d;
      out_mask  <= mask_d;
      out_count <= count_d;
      out_sum   <= sum_d;
      out_list  <= list_d;
    end
  end
endmodule

// File: rtl/zsp_packer_chk.sv
module zsp_packer_chk #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned SUM_W  = 16,
  parameter int unsigned LIST_W = 64
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [NUM_CH-1:0] out_mask,
  input logic [CNT_W-1:0]  out_count,
  input logic [SUM_W-1:0]  out_sum,
  input logic [LIST_W-1:0] out_list
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);                                         // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);                                       // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_mask) && $stable(out_count) &&
                   $stable(out_sum) && $stable(out_list)));          // R9
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_count == CNT_W'($countones(out_mask)));                      // R5
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_list >> (32'(out_count) * 4)) == '0);                       // R4
  AST_EMPTY_SUM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_mask == '0) |-> (out_sum == '0));                           // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && out_mask == '0 && out_sum == '0)); // R10
endmodule

bind zsp_packer zsp_packer_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .SUM_W  (SUM_W),
  .LIST_W (LIST_W)
) i_zsp_packer_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_mask   (out_mask),
  .out_count  (out_count),
  .out_sum    (out_sum),
  .out_list   (out_list)
);

// File: tb/test_zsp_packer.sv
`timescale 1ns/1ps
module test_zsp_packer;
  localparam int NCH = 16;
  localparam int AW  = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [NCH*AW-1:0] in_samples;
  logic [AW-1:0] in_thresh;
  logic [3:0]    in_shift;
  logic          out_valid;
  logic [15:0]   out_mask;
  logic [4:0]    out_count;
  logic [15:0]   out_sum;
  logic [63:0]   out_list;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [15:0] e_mask;
  logic [4:0]  e_count;
  logic [15:0] e_sum;
  logic [63:0] e_list;

  always #2 clk = ~clk;

  zsp_packer i_zsp_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
    .in_thresh(in_thresh), .in_shift(in_shift), .out_valid(out_valid),
    .out_mask(out_mask), .out_count(out_count), .out_sum(out_sum),
    .out_list(out_list)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected frame computed from the requirements
  task automatic model(input logic [NCH*AW-1:0] s, input logic [AW-1:0] th,
                       input logic [3:0] sh);
    int acc;
    int slot;
    acc = 0; slot = 0;
    e_mask = '0; e_list = '0;
    for (int i = 0; i < NCH; i++) begin
      int v;
      int c;
      v = int'(s[i*AW +: AW]);
      if (v > int'(th)) begin
        e_mask[i] = 1'b1;
        acc += v;
        c = v >> sh;
        if (c > 15) c = 15;
        e_list[slot*4 +: 4] = 4'(c);
        slot++;
      end
    end
    e_count = 5'(slot);
    e_sum   = (acc > 65535) ? 16'hFFFF : 16'(acc);
  endtask

  task automatic frame(input bit v, input logic [NCH*AW-1:0] s,
                       input logic [AW-1:0] th, input logic [3:0] sh,
                       input bit verbose);
    in_valid = v; in_samples = s; in_thresh = th; in_shift = sh;
    if (v) model(s, th, sh);
    @(negedge clk);
    if (v) begin
      check("R8 valid", 64'(out_valid), 64'(1));
      check("R1 mask", 64'(out_mask), 64'(e_mask));
      check("R5 count", 64'(out_count), 64'(e_count));
      check("R6 R7 sum", 64'(out_sum), 64'(e_sum));
      check("R2 R3 R4 list", out_list, e_list);
    end else begin
      check("R9 valid low", 64'(out_valid), 64'(0));
      check("R9 hold mask", 64'(out_mask), 64'(e_mask));
      check("R9 hold sum", 64'(out_sum), 64'(e_sum));
      check("R9 hold list", out_list, e_list);
      check("R9 hold count", 64'(out_count), 64'(e_count));
    end
    if (verbose) ;
  endtask

  function automatic logic [NCH*AW-1:0] fill(int val);
    logic [NCH*AW-1:0] r;
    for (int i = 0; i < NCH; i++) r[i*AW +: AW] = AW'(val);
    return r;
  endfunction

  initial begin
    logic [NCH*AW-1:0] s;
    void'($urandom(32'h1DEA5));
    rst_n = 1'b0; in_valid = 0; in_samples = '0; in_thresh = '0; in_shift = '0;
    e_mask = '0; e_count = '0; e_sum = '0; e_list = '0;
    repeat (3) @(negedge clk);
    // R10: outputs cleared during reset
    check("R10 valid", 64'(out_valid), 64'(0));
    check("R10 mask", 64'(out_mask), 64'(0));
    check("R10 list", out_list, 64'(0));
    check("R10 sum", 64'(out_sum), 64'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: equal to threshold is not a hit
    frame(1, fill(100), 14'd100, 4'd0, 0);
    // R1 R2: one above threshold, clamp to 15 at shift 0
    frame(1, fill(101), 14'd100, 4'd0, 0);
    // R2: shift brings 101>>4 = 6
    frame(1, fill(101), 14'd100, 4'd4, 0);
    // R7: all channels at full scale saturate the sum
    frame(1, fill(16383), 14'd0, 4'd13, 0);
    // R3 R4: sparse pattern, channels 3, 9, 15 with distinct codes
    s = fill(5);
    s[3*AW +: AW] = 14'd80; s[9*AW +: AW] = 14'd48; s[15*AW +: AW] = 14'd16;
    frame(1, s, 14'd10, 4'd4, 0);
    // R9: idle clocks keep the last frame
    frame(0, fill(9000), 14'd0, 4'd0, 0);
    frame(0, fill(1), 14'd0, 4'd0, 0);
    // R6: no hits, sum zero
    frame(1, fill(7), 14'd16383, 4'd0, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [NCH*AW-1:0] r;
      bit v;
      int range;
      range = (n % 3 == 0) ? 16383 : ((n % 3 == 1) ? 255 : 4095);
      for (int i = 0; i < NCH; i++) r[i*AW +: AW] = AW'($urandom % (range + 1));
      v = ($urandom % 4) != 0;
      frame(v, r, AW'($urandom % (range + 1)), 4'($urandom % 16), 0);
    end

    // R10: asynchronous reset mid-stream clears outputs without a clock
    @(posedge clk); #1;
    rst_n = 1'b0; #0.5;
    check("R10 async mask", 64'(out_mask), 64'(0));
    check("R10 async valid", 64'(out_valid), 64'(0));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule